// File: doc/BRIEF.md
# SDRAM Precharge Spacing Timer

This block holds off row-level commands to one SDRAM bank pair for as long as an auto-precharge read or write may still be closing its row. A command scheduler samples `row_ok` before it latches a bank activate, a mode register set, a self-refresh entry or a CBR refresh on a clock edge. The bank pair runs those commands only when `row_ok` is high.

The block takes three timing fields and a half-rate flag. The precharge field `cfg_trp` is stored as the required number of memory cycles minus one. `cfg_tdl` gives the read data latency and `cfg_twr` gives the write recovery. Three strobes, each one cycle wide, mark events on a clock edge: `rd_ap` for a latched read with auto-precharge, `wr_ap` for a latched write with auto-precharge and its data, and `data_latch` for the edge that latches read data. A single down-counter holds the largest spacing still owed, and `row_ok` is high exactly when that counter is zero. The fields are captured when a command is accepted. Reprogramming them later does not change a hold-off that is already running.

Top module: `spt_precharge_timer`

## Requirements
- R1: After reset, `row_ok` is 1. With no strobe asserted it stays 1.
- R2: With `cfg_half`=0, an `rd_ap` sampled at edge t lets the next row command be latched no earlier than edge t+G, where G = `cfg_tdl` + `cfg_trp` + 2. `row_ok` is 0 after edges t through t+G-2 and 1 after edge t+G-1.
- R3: With `cfg_half`=0, a `wr_ap` sampled at edge t gives the same window with G = `cfg_trp` + `cfg_twr` + 1.
- R4: With `cfg_half`=1, each `cfg_tdl` unit counts as two cycles and the effective precharge value is `cfg_trp`+1. `cfg_twr` keeps its one-cycle unit. The read spacing is therefore 2·tdl + trp + 3 and the write spacing is trp + twr + 2.
- R5: A `data_latch` sampled at edge t while a read with auto-precharge is outstanding blocks row commands until edge t + P + 2, where P is the effective precharge value captured with that read. This holds for at least P+1 cycles after the first edge that follows the data latch.
- R6: When hold-offs overlap, the later of the two end points applies. A new strobe never shortens a window that is already running.
- R7: The timing fields are captured on the edge that accepts the strobe. Changing them during a running window does not move its end.
- R8: `cfg_err` is 1 exactly when `cfg_trp` is 0. It is combinational and has no effect on timing.
- R9: A `data_latch` with no read outstanding is ignored. `row_ok` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trp | input | 4 | Precharge cycles minus one |
| cfg_tdl | input | 2 | Read data latency |
| cfg_twr | input | 2 | Write recovery cycles |
| cfg_half | input | 1 | 1 = SDRAM clock at half rate |
| rd_ap | input | 1 | Read with auto-precharge latched this edge |
| wr_ap | input | 1 | Write with auto-precharge and data latched this edge |
| data_latch | input | 1 | Read data latched this edge |
| row_ok | output | 1 | Row-level command may be latched on the next edge |
| cfg_err | output | 1 | Precharge field programmed to zero |

## Verification
Three kinds of stimulus exercise the spacing:

- **Isolated strobes.** Single reads and writes at the smallest and largest field values, at full and half rate. The exact length of the low window of `row_ok` separates the read formula from the write formula and shows the half-rate doubling and the extra cycle.
- **Strobe pairs.** A long write followed by a short read, and a short read followed by a long write. These show that the longer window wins in either order. A read followed by a late data latch shows that the latch can extend the window past the read's own spacing.
- **Stray latch and reprogramming.** A data latch with no read outstanding shows that a stray latch is ignored. Field changes inside a running window show that the fields were captured at acceptance.

// File: rtl/spt_pkg.sv
package spt_pkg;

  // Effective precharge value: half rate adds one cycle of command setup.
  function automatic int unsigned trp_eff(input int unsigned trp, input bit half);
    return trp + (half ? 1 : 0);
  endfunction

  // Read latency in memory cycles: half rate doubles the unit.
  function automatic int unsigned tdl_eff(input int unsigned tdl, input bit half);
    return half ? (tdl * 2) : tdl;
  endfunction

  // Hold values are the spacing minus one (the counter value after the strobe edge).
  function automatic int unsigned rd_hold(input int unsigned trp_e, input int unsigned tdl_e);
    return tdl_e + trp_e + 1;
  endfunction

  function automatic int unsigned wr_hold(input int unsigned trp_e, input int unsigned twr);
    return trp_e + twr;
  endfunction

  function automatic int unsigned dl_hold(input int unsigned trp_e);
    return trp_e + 1;
  endfunction

  function automatic int unsigned max_hold(input int trp_w, input int tdl_w, input int twr_w);
    int unsigned tp;
    int unsigned rd;
    int unsigned wr;
    tp = (2 ** trp_w);
    rd = 2 * ((2 ** tdl_w) - 1) + tp + 1;
    wr = tp + (2 ** twr_w) - 1;
    return (rd > wr) ? rd : wr;
  endfunction

endpackage

// File: rtl/spt_hold_calc.sv
module spt_hold_calc
  import spt_pkg::*;
#(
  parameter int TRP_W = 4,
  parameter int TDL_W = 2,
  parameter int TWR_W = 2,
  parameter int CNT_W = 5
) (
  input  logic [TRP_W-1:0] cfg_trp,
  input  logic [TDL_W-1:0] cfg_tdl,
  input  logic [TWR_W-1:0] cfg_twr,
  input  logic             cfg_half,
  input  logic             rd_ap,
  input  logic             wr_ap,
  input  logic             dl_hit,
  input  logic [TRP_W:0]   trp_held,
  output logic [TRP_W:0]   trp_eff_now,
  output logic             req_valid,
  output logic [CNT_W-1:0] req
);
  logic [CNT_W-1:0] rd_req, wr_req, dl_req, m1;

  always_comb begin
    trp_eff_now = (TRP_W+1)'(trp_eff(32'(cfg_trp), cfg_half));
    rd_req = rd_ap ? CNT_W'(rd_hold(32'(trp_eff_now), tdl_eff(32'(cfg_tdl), cfg_half))) : '0;
    wr_req = wr_ap ? CNT_W'(wr_hold(32'(trp_eff_now), 32'(cfg_twr))) : '0;
    dl_req = dl_hit ? CNT_W'(dl_hold(32'(trp_held))) : '0;
    m1 = (rd_req > wr_req) ? rd_req : wr_req;
    req = (m1 > dl_req) ? m1 : dl_req;
    req_valid = rd_ap | wr_ap | dl_hit;
  end
endmodule

// File: rtl/spt_read_tracker.sv
module spt_read_tracker #(
  parameter int TRP_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_ap,
  input  logic           data_latch,
  input  logic           cnt_zero,
  input  logic [TRP_W:0] trp_eff_now,
  output logic           rd_pend,
  output logic           dl_hit,
  output logic [TRP_W:0] trp_held
);
  assign dl_hit = data_latch & rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend  <= 1'b0;
      trp_held <= '0;
    end else if (rd_ap) begin
      rd_pend  <= 1'b1;
      trp_held <= trp_eff_now;
    end else if (dl_hit || cnt_zero) begin
      rd_pend  <= 1'b0;
    end
  end
endmodule

// File: rtl/spt_hold_counter.sv
module spt_hold_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] req,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] dec, nxt;

  always_comb begin
    dec = (cnt != '0) ? cnt - 1'b1 : '0;
    nxt = (req_valid && (req > dec)) ? req : dec;
  end

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  AST_LOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (cnt >= $past(req))); // R6
  AST_NO_SHORTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> (cnt >= $past(cnt) - 1'b1)); // R6
endmodule

// File: rtl/spt_precharge_timer.sv
module spt_precharge_timer
  import spt_pkg::*;
#(
  parameter int TRP_W = 4,
  parameter int TDL_W = 2,
  parameter int TWR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TRP_W-1:0] cfg_trp,
  input  logic [TDL_W-1:0] cfg_tdl,
  input  logic [TWR_W-1:0] cfg_twr,
  input  logic             cfg_half,
  input  logic             rd_ap,
  input  logic             wr_ap,
  input  logic             data_latch,
  output logic             row_ok,
  output logic             cfg_err
);
  localparam int unsigned MAX_HOLD = max_hold(TRP_W, TDL_W, TWR_W);
  localparam int CNT_W = $clog2(MAX_HOLD + 1);

  logic [TRP_W:0]   trp_eff_now, trp_held;
  logic             rd_pend, dl_hit, cnt_zero, req_valid;
  logic [CNT_W-1:0] req, cnt;

  spt_hold_calc #(.TRP_W(TRP_W), .TDL_W(TDL_W), .TWR_W(TWR_W), .CNT_W(CNT_W)) u_calc (
    .cfg_trp(cfg_trp), .cfg_tdl(cfg_tdl), .cfg_twr(cfg_twr), .cfg_half(cfg_half),
    .rd_ap(rd_ap), .wr_ap(wr_ap), .dl_hit(dl_hit), .trp_held(trp_held),
    .trp_eff_now(trp_eff_now), .req_valid(req_valid), .req(req)
  );

  spt_read_tracker #(.TRP_W(TRP_W)) u_track (
    .clk(clk), .rst_n(rst_n), .rd_ap(rd_ap), .data_latch(data_latch),
    .cnt_zero(cnt_zero), .trp_eff_now(trp_eff_now),
    .rd_pend(rd_pend), .dl_hit(dl_hit), .trp_held(trp_held)
  );

  spt_hold_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req(req),
    .cnt(cnt), .cnt_zero(cnt_zero)
  );

  assign row_ok  = cnt_zero;
  assign cfg_err = (cfg_trp == '0);

  AST_RESET_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> row_ok); // R1
  AST_RD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ap |=> !row_ok); // R2
  AST_WR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ap |=> !row_ok); // R3
  AST_STRAY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (data_latch && !rd_pend && !rd_ap && !wr_ap && row_ok) |=> row_ok); // R9
endmodule

// File: tb/spt_precharge_timer_bench.sv
module spt_precharge_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_trp = 4'd1;
  logic [1:0] cfg_tdl = 2'd0;
  logic [1:0] cfg_twr = 2'd0;
  logic cfg_half = 1'b0;
  logic rd_ap = 1'b0, wr_ap = 1'b0, data_latch = 1'b0;
  logic row_ok, cfg_err;

  int n_chk = 0, n_bad = 0, edge_n = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  spt_precharge_timer u_spt_precharge_timer (
    .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_tdl(cfg_tdl),
    .cfg_twr(cfg_twr), .cfg_half(cfg_half), .rd_ap(rd_ap), .wr_ap(wr_ap),
    .data_latch(data_latch), .row_ok(row_ok), .cfg_err(cfg_err)
  );

  // Spacing from the strobe edge, restated from the requirements.
  function automatic int rd_gap(int trp, int tdl, bit half);
    return half ? (trp + 2 * tdl + 3) : (trp + tdl + 2);
  endfunction
  function automatic int wr_gap(int trp, int twr, bit half);
    return trp + twr + (half ? 2 : 1);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(int trp, int tdl, int twr, bit half);
    cfg_trp = 4'(trp); cfg_tdl = 2'(tdl); cfg_twr = 2'(twr); cfg_half = half;
  endtask

  // Drive one strobe cycle; return the index of the edge that sampled it.
  task automatic pulse(bit r, bit w, bit d, output int t);
    @(negedge clk);
    rd_ap = r; wr_ap = w; data_latch = d;
    @(negedge clk);
    rd_ap = 1'b0; wr_ap = 1'b0; data_latch = 1'b0;
    t = edge_n;
  endtask

  // Count low samples of row_ok from now; expect allowed edge a after last edge t.
  task automatic window(string req, int a, int t);
    int n = 0;
    int exp = (a - 1 - t > 0) ? (a - 1 - t) : 0;
    while (!row_ok && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(req, n, exp);
  endtask

  task automatic t_reset();
    check("R1 row_ok after reset", int'(row_ok), 1);
    repeat (5) @(negedge clk);
    check("R1 row_ok idle", int'(row_ok), 1);
  endtask

  task automatic t_read(int trp, int tdl);
    int t;
    set_cfg(trp, tdl, 0, 1'b0);
    pulse(1, 0, 0, t);
    window("R2 read spacing", t + rd_gap(trp, tdl, 1'b0), t);
  endtask

  task automatic t_write(int trp, int twr);
    int t;
    set_cfg(trp, 0, twr, 1'b0);
    pulse(0, 1, 0, t);
    window("R3 write spacing", t + wr_gap(trp, twr, 1'b0), t);
  endtask

  task automatic t_half();
    int t;
    set_cfg(2, 3, 1, 1'b1);
    pulse(1, 0, 0, t);
    window("R4 half-rate read", t + rd_gap(2, 3, 1'b1), t);
    pulse(0, 1, 0, t);
    window("R4 half-rate write", t + wr_gap(2, 1, 1'b1), t);
    set_cfg(1, 0, 0, 1'b0);
  endtask

  task automatic t_latch();
    int t0, t1, a;
    set_cfg(3, 1, 0, 1'b0);
    pulse(1, 0, 0, t0);
    @(negedge clk);
    pulse(0, 0, 1, t1);
    a = t0 + rd_gap(3, 1, 1'b0);
    if (t1 + 3 + 2 > a) a = t1 + 3 + 2;
    window("R5 data latch extends", a, t1);
  endtask

  task automatic t_overlap();
    int t0, t1, a;
    set_cfg(9, 0, 3, 1'b0);
    pulse(0, 1, 0, t0);
    set_cfg(1, 0, 0, 1'b0);
    pulse(1, 0, 0, t1);
    a = t0 + wr_gap(9, 3, 1'b0);
    if (t1 + rd_gap(1, 0, 1'b0) > a) a = t1 + rd_gap(1, 0, 1'b0);
    window("R6 long write then short read", a, t1);
    pulse(1, 0, 0, t0);
    set_cfg(9, 0, 3, 1'b0);
    pulse(0, 1, 0, t1);
    window("R6 short read then long write", t1 + wr_gap(9, 3, 1'b0), t1);
  endtask

  task automatic t_reprog();
    int t;
    set_cfg(2, 1, 0, 1'b0);
    pulse(1, 0, 0, t);
    set_cfg(15, 3, 3, 1'b1);
    window("R7 fields captured at accept", t + rd_gap(2, 1, 1'b0), t);
    set_cfg(1, 0, 0, 1'b0);
  endtask

  task automatic t_cfg_err();
    set_cfg(0, 0, 0, 1'b0);
    #1 check("R8 cfg_err on zero", int'(cfg_err), 1);
    set_cfg(5, 0, 0, 1'b0);
    #1 check("R8 cfg_err clear", int'(cfg_err), 0);
  endtask

  task automatic t_stray();
    int t;
    int lows = 0;
    repeat (3) @(negedge clk);
    pulse(0, 0, 1, t);
    repeat (10) begin
      if (!row_ok) lows++;
      @(negedge clk);
    end
    check("R9 stray latch ignored", lows, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(1, 0);
    t_read(15, 3);
    t_read(4, 2);
    t_write(1, 0);
    t_write(9, 3);
    t_half();
    t_latch();
    t_overlap();
    t_reprog();
    t_cfg_err();
    t_stray();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule